// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous host and an external byte-wide asynchronous static RAM with 19 address lines. The host hands over one read or write at a time on a valid/ready request port. The controller then drives the active-low chip select, write strobe and output strobe of the memory. Each phase is held for a whole number of clock cycles. That number is worked out at elaboration from nanosecond timing values and the clock period.

The shared data bus is split at the block edge into an input byte, an output byte and a driver-enable flag, so the pad ring decides how they meet. A write keeps the output strobe high. The controller turns its drivers on only after the memory's output-release delay has passed, and keeps them on for at least one cycle after the write strobe rises. A read holds both strobes low for the access time, samples the byte on the last cycle, and returns it with a one-cycle response pulse. Between operations the chip select stays high, so the memory sits in standby.

A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a host that keeps `req_valid` high waits until the current operation has finished. The response port has no back-pressure: `rsp_valid` is a single-cycle pulse and the host must take the byte in that cycle.

Top module: `sram_async_ctl`

## Requirements
- R1: Out of reset and whenever idle, chip select, write strobe and output strobe are all high (1), the data drivers are off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the operation ends, so a request that is held during an operation is accepted only once.
- R3: For a read (`req_write`=0), chip select and output strobe go low on the edge that accepts the request and stay low for N_ACC cycles, with the write strobe high. The byte on `mem_dq_i` is sampled on the last of those edges. `rsp_valid` is 1 for exactly one cycle after that edge, and `rsp_rdata` carries the byte. As a result, `rsp_valid` is first seen N_ACC+1 falling edges after acceptance, counting the falling edge just after the accepting edge as the first.
- R4: After a read, chip select and output strobe rise together and stay high for N_REL cycles before `req_ready` returns. `req_ready` is first seen N_ACC+N_REL+1 falling edges after acceptance.
- R5: For a write (`req_write`=1), the output strobe stays high throughout. Chip select is low for N_AS cycles before the write strobe falls. The write strobe is then low for N_PULSE cycles, and the write strobe is never low while chip select is high or while the output strobe is low. `req_ready` is first seen N_AS+N_PULSE+N_DH+1 falling edges after acceptance.
- R6: `mem_addr` changes only on an accepting edge, so it never changes while the write strobe is low.
- R7: During a write, the drivers turn on N_WHZ cycles after the write strobe falls and stay on for at least N_DW cycles before it rises. The drivers and address stay unchanged for N_DH cycles after it rises. The drivers are never on while the memory could still be driving the bus after a read, that is, during a read or within the memory's release time after one.
- R8: Every phase length is ceil(t_ns / CLK_PERIOD_NS), with a minimum of 1. SPEED_GRADE=70 selects access 70, release 35, write-to-float 30, pulse 35, address-to-end 70, cycle 70, data setup 30, address setup 0 and hold 0. SPEED_GRADE=100 selects 100/40/40/50/100/100/40/0/0. N_PULSE is the largest of N_WP, N_WHZ+N_DW, N_AW and N_WC-N_AS-N_DH. At 5 ns and grade 70 this gives N_ACC=14, N_REL=7, N_WHZ=6, N_DW=6, N_AS=1, N_DH=1 and N_PULSE=14.
- R9: A byte written to any 19-bit address, including 0 and 0x7FFFF, is returned unchanged by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Controller data-driver enable |
| mem_dq_i | input | 8 | Byte received from the memory bus |

## Verification
The assertions take for granted only that reset is applied before the first operation and that the host inputs are synchronous to `clk`. They place no conditions on `mem_dq_i` and no holding rules on `req_valid`, because the controller captures the request only on the accepting edge. The stimulus changes host inputs only on falling edges. The memory model returns a valid byte only once its strobes have been low for the full access time, and it keeps the bus claimed for its release time afterwards. As a result, early sampling or early driver turn-on shows up at the ports.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REL,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } ctl_state_e;

  typedef struct packed {
    int acc_ns;   // address/select access
    int rel_ns;   // deselect to bus float
    int whz_ns;   // write strobe low to bus float
    int wp_ns;    // write pulse width
    int aw_ns;    // address valid to end of write
    int wc_ns;    // write cycle
    int dw_ns;    // data setup before end of write
    int as_ns;    // address setup before write strobe
    int dh_ns;    // data hold after end of write
  } sram_timing_t;

  function automatic sram_timing_t grade_timing(input int grade);
    sram_timing_t t;
    if (grade == 100) begin
      t = '{acc_ns: 100, rel_ns: 40, whz_ns: 40, wp_ns: 50, aw_ns: 100,
            wc_ns: 100, dw_ns: 40, as_ns: 0, dh_ns: 0};
    end else begin
      t = '{acc_ns: 70, rel_ns: 35, whz_ns: 30, wp_ns: 35, aw_ns: 70,
            wc_ns: 70, dw_ns: 30, as_ns: 0, dh_ns: 0};
    end
    return t;
  endfunction

  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_d,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q == '0)  cnt_d = '0;
    else                   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

  // R8: a running phase never wraps below zero
  a_r8_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0) || $past(load));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= din;
    end
  end

  // R3: response is a single-cycle pulse
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  // R3: returned byte holds between pulses
  a_r3_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(rdata));

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int SPEED_GRADE   = 70,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam sram_timing_t TM = grade_timing(SPEED_GRADE);

  localparam int N_ACC   = ns_to_cycles(TM.acc_ns, CLK_PERIOD_NS);
  localparam int N_REL   = ns_to_cycles(TM.rel_ns, CLK_PERIOD_NS);
  localparam int N_WHZ   = ns_to_cycles(TM.whz_ns, CLK_PERIOD_NS);
  localparam int N_WP    = ns_to_cycles(TM.wp_ns,  CLK_PERIOD_NS);
  localparam int N_AW    = ns_to_cycles(TM.aw_ns,  CLK_PERIOD_NS);
  localparam int N_WC    = ns_to_cycles(TM.wc_ns,  CLK_PERIOD_NS);
  localparam int N_DW    = ns_to_cycles(TM.dw_ns,  CLK_PERIOD_NS);
  localparam int N_AS    = ns_to_cycles(TM.as_ns,  CLK_PERIOD_NS);
  localparam int N_DH    = ns_to_cycles(TM.dh_ns,  CLK_PERIOD_NS);
  localparam int N_PULSE = max2(max2(N_WP, N_WHZ + N_DW),
                                max2(N_AW, N_WC - N_AS - N_DH));
  localparam int DRV_LIM = N_PULSE - N_WHZ;
  localparam int N_MAX   = max2(max2(max2(N_ACC, N_REL), max2(N_PULSE, N_AS)), N_DH);
  localparam int CNT_W   = $clog2(N_MAX + 1);

  ctl_state_e state_q, state_d;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val, tmr_cnt_d;
  logic             accept, capture;
  logic             ce_n_d, we_n_d, oe_n_d, drv_d;

  assign accept  = req_valid && (state_q == ST_IDLE);
  assign capture = (state_q == ST_RD_ACC) && tmr_last;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt_d    (tmr_cnt_d),
    .last     (tmr_last)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .din     (mem_dq_i),
    .rvalid  (rsp_valid),
    .rdata   (rsp_rdata)
  );

  // phase sequencing
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WR_SETUP;
          tmr_val = CNT_W'(N_AS - 1);
        end else begin
          state_d = ST_RD_ACC;
          tmr_val = CNT_W'(N_ACC - 1);
        end
      end
      ST_RD_ACC: if (tmr_last) begin
        state_d  = ST_RD_REL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_REL - 1);
      end
      ST_RD_REL: if (tmr_last) state_d = ST_IDLE;
      ST_WR_SETUP: if (tmr_last) begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_PULSE - 1);
      end
      ST_WR_PULSE: if (tmr_last) begin
        state_d  = ST_WR_HOLD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_DH - 1);
      end
      ST_WR_HOLD: if (tmr_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // next values of the registered memory-side controls
  always_comb begin
    ce_n_d = !((state_d == ST_RD_ACC) || (state_d == ST_WR_SETUP) ||
               (state_d == ST_WR_PULSE));
    oe_n_d = (state_d != ST_RD_ACC);
    we_n_d = (state_d != ST_WR_PULSE);
    drv_d  = ((state_d == ST_WR_PULSE) && (tmr_cnt_d < CNT_W'(DRV_LIM))) ||
             (state_d == ST_WR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
    end else begin
      state_q   <= state_d;
      mem_ce_n  <= ce_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= drv_d;
      if (accept) begin
        mem_addr <= req_addr;
        if (req_write) mem_dq_o <= req_wdata;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  // R1: idle means memory deselected and bus released
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R5: write strobe only inside a selected, output-disabled cycle
  a_r5_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R6: address frozen while write strobe is low
  a_r6_addr_stable_we_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));

  // R7: never drive while the memory output strobe is active
  a_r7_no_drv_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7: drivers switch on only inside the write pulse
  a_r7_drv_on_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> !mem_we_n);

  // R7: data still driven when the write strobe rises
  a_r7_drv_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

  // R2: no new acceptance while busy
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb;

  localparam int PER   = 5;
  localparam int E_ACC = (70 + PER - 1) / PER;
  localparam int E_REL = (35 + PER - 1) / PER;
  localparam int E_WHZ = (30 + PER - 1) / PER;
  localparam int E_DW  = (30 + PER - 1) / PER;
  localparam int E_AW  = (70 + PER - 1) / PER;
  localparam int E_AS  = 1;
  localparam int E_DH  = 1;
  localparam int E_PULSE = E_AW;  // largest of 7, 12, 14, 12
  localparam int E_WR  = E_AS + E_PULSE + E_DH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hEE;

  int checks = 0, failures = 0, cyc = 0;
  int commits = 0;
  logic [7:0] mem_model [int];

  always #2.5 clk = ~clk;

  sram_async_ctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // memory model, evaluated on falling edges
  bit          we_prev = 1'b1;
  int          we_lo = 0, drv_lo = 0, drv_first = -1, rd_lo = 0, rel = 0;
  logic [18:0] addr_fall = '0;

  always @(negedge clk) begin
    bit drive_now;
    if (rst_n) begin
      if (!mem_we_n) begin
        if (we_prev) begin
          we_lo = 0; drv_lo = 0; drv_first = -1; addr_fall = mem_addr;
        end
        we_lo++;
        if (mem_dq_oe) begin
          if (drv_first < 0) drv_first = we_lo - 1;
          drv_lo++;
        end
        check(mem_addr == addr_fall, "R6 address moved under write strobe",
              int'(mem_addr), int'(addr_fall));
        check(mem_oe_n && !mem_ce_n, "R5 strobes during write",
              {mem_oe_n, mem_ce_n}, 2);
      end else if (!we_prev) begin
        check(we_lo == E_PULSE, "R5 write pulse cycles", we_lo, E_PULSE);
        check(drv_first == E_WHZ, "R7 driver turn-on delay", drv_first, E_WHZ);
        check(drv_lo >= E_DW, "R7 data setup cycles", drv_lo, E_DW);
        check(mem_dq_oe && mem_addr == addr_fall, "R7 hold after write strobe",
              int'(mem_dq_oe), 1);
        mem_model[int'(addr_fall)] = mem_dq_o;
        commits++;
      end
      drive_now = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (mem_dq_oe)
        check(!drive_now && rel == 0, "R7 bus contention", rel, 0);
      if (drive_now) rel = E_REL - 1;
      else if (rel > 0) rel--;
      if (drive_now) begin
        rd_lo++;
        if (rd_lo >= E_ACC)
          mem_dq_i = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 8'h00;
        else
          mem_dq_i = 8'hEE;
      end else begin
        rd_lo = 0;
        mem_dq_i = 8'hEE;
      end
    end
    we_prev = mem_we_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      check(1'b0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  // present a request; returns at the falling edge after the accepting edge
  task automatic send(input logic wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int n = 1;
    int c0 = commits;
    send(1'b1, a, d);
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    check(n == E_WR + 1, "R5 R8 write duration", n, E_WR + 1);
    check(commits == c0 + 1, "R2 one write per request", commits - c0, 1);
    check(mem_ce_n && mem_we_n && !mem_dq_oe, "R1 idle after write",
          {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b110);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
    int n = 1;
    send(1'b0, a, 8'h00);
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    check(n == E_ACC + 1, "R3 R8 read latency", n, E_ACC + 1);
    check(rsp_rdata == exp, "R9 read data", int'(rsp_rdata), int'(exp));
    check(mem_ce_n && mem_oe_n && !req_ready, "R4 release begins",
          {mem_ce_n, mem_oe_n, req_ready}, 3'b110);
    @(negedge clk); n++;
    check(!rsp_valid, "R3 single-cycle response", int'(rsp_valid), 0);
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    check(n == E_ACC + E_REL + 1, "R4 release length", n, E_ACC + E_REL + 1);
  endtask

  task automatic test_reset();
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 memory idle at reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    check(req_ready && !rsp_valid, "R1 host side at reset",
          {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic test_patterns();
    do_write(19'h00000, 8'h5A);
    do_write(19'h7FFFF, 8'hFF);
    do_write(19'h2AAAA, 8'h00);
    do_write(19'h55555, 8'hA5);
    do_read(19'h00000, 8'h5A);
    do_read(19'h7FFFF, 8'hFF);
    do_read(19'h2AAAA, 8'h00);
    do_read(19'h55555, 8'hA5);
    do_write(19'h00000, 8'h3C);
    do_read(19'h00000, 8'h3C);
    do_read(19'h7FFFF, 8'hFF);
  endtask

  // request held during a read: accepted once, after the read ends
  task automatic test_held_request();
    int n = 1;
    int c0 = commits;
    send(1'b0, 19'h55555, 8'h00);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h12345; req_wdata = 8'hC3;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    check(rsp_rdata == 8'hA5, "R2 read completes under held request",
          int'(rsp_rdata), 8'hA5);
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    check(n == E_ACC + E_REL + 1, "R2 held request waits for ready",
          n, E_ACC + E_REL + 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check(commits == c0 + 1, "R2 held request accepted once", commits - c0, 1);
    do_read(19'h12345, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_patterns();
    test_held_request();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule